// File: doc/BRIEF.md
# Power-Down Wake-Up Monitor

This block runs the sleep phase of a three-wire host link on a small multi-channel converter. Once the command decoder flags that the current transaction carries a sleep command, the monitor counts host clock rising edges from the falling edge of the active-low transaction strobe. On the eighth edge it enters sleep, takes over the data line, and drives a resting level picked by the sleep mode. A resting level of 0 is used in mode 0 and a resting level of 1 in mode 1.

While asleep, the monitor watches every channel that is configured as a digital input and has wake-up enabled. The first level change on such a channel inverts the data line. The line then holds that value, and all later channel activity is ignored until the host raises the strobe. The strobe high ends the sleep phase and releases the data line. All channel, strobe and host clock inputs are asynchronous. They are synchronized on a free-running system clock, so detection still works when the host clock is stopped during sleep.

A warning output reports that a reference-select bit was nonzero at sleep entry, because such a setting defeats the low standby current. The analog power gating is represented only by the `powered_down` status.

Top module: `pdw_monitor`

## Requirements
- R1: After reset, `powered_down`, `dio_oe`, `dio_out`, `wake_seen` and `ref_warn` are all 0.
- R2: When `pd_cmd` is 1, `powered_down` rises after the 8th rising edge of `sclk_in` counted from the fall of `start_in`, and is still 0 after the 7th.
- R3: When `pd_cmd` is 0, any number of `sclk_in` edges leaves `powered_down` and `dio_oe` at 0.
- R4: Mode 0 (`pd_mode`=0 at entry): while asleep, `dio_oe`=1 and `dio_out`=0. A wake event sets `dio_out` to 1.
- R5: Mode 1 (`pd_mode`=1 at entry): while asleep, `dio_oe`=1 and `dio_out`=1. A wake event sets `dio_out` to 0.
- R6: A wake event is a rising or a falling level change on channel i with `chan_analog[i]`=0 (digital) and `wake_en[i]`=1. It sets `wake_seen`.
- R7: Level changes on channels with `chan_analog[i]`=1, or with `wake_en[i]`=0, leave `dio_out` at its resting level.
- R8: After a wake event, further channel changes leave `dio_out` and `wake_seen` unchanged while `start_in` stays low.
- R9: `start_in` returning high ends sleep: `powered_down`, `dio_oe`, `dio_out` and `wake_seen` return to 0.
- R10: Wake detection needs no `sclk_in` edges; it works with the host clock held still for the whole sleep phase.
- R11: `ref_warn` is 1 while asleep if `ref_int` or `ref_ext` was 1 at entry, 0 if both were 0, and is cleared when sleep ends.
- R12: The mode is captured at entry; changing `pd_mode` during sleep does not alter `dio_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_in | input | 1 | Host transaction strobe, active low, asynchronous |
| sclk_in | input | 1 | Host serial clock, asynchronous, may stop |
| chan_in | input | NCH | Channel digital levels, asynchronous |
| chan_analog | input | NCH | Per-channel type, 1 = analog, 0 = digital |
| wake_en | input | NCH | Per-channel wake-up enable, 1 = enabled |
| pd_cmd | input | 1 | Decoded: current transaction is a sleep command |
| pd_mode | input | 1 | Decoded sleep mode, 0 or 1 |
| ref_int | input | 1 | Internal reference select bit |
| ref_ext | input | 1 | External reference select bit |
| dio_out | output | 1 | Data line value while driven |
| dio_oe | output | 1 | Data line drive enable (0 = high impedance) |
| powered_down | output | 1 | Sleep status |
| wake_seen | output | 1 | Wake event latched in this sleep phase |
| ref_warn | output | 1 | Reference bits nonzero at sleep entry |

## Verification
The entry count is probed on both sides of the boundary, after seven and after eight host clock edges, and again with no sleep command to show that the count alone does not trigger sleep. Wake detection is tried with a rising change in mode 0 and a falling change in mode 1. This separates a real level-change detector from one that only sees rising edges, and checks that the inversion follows the latched mode. Changes on an analog channel that is enabled and on a digital channel that is disabled are applied before any qualifying change, which exposes a wrong qualification mask. Extra changes after the wake event, with the host clock held still, confirm the latch and that detection does not depend on the clock.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMD   = 2'd1,
        ST_SLEEP = 2'd2,
        ST_WOKE  = 2'd3
    } pdw_state_e;
endpackage

// File: rtl/pdw_sync.sv
module pdw_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= RST_VAL;
        end else begin
            stage_q[0] <= d_in;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/pdw_edge.sv
module pdw_edge #(
    parameter int           W         = 1,
    parameter bit           RISE_ONLY = 1'b0,
    parameter logic [W-1:0] RST_VAL   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    output logic [W-1:0] evt
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= cur;
    end

    generate
        if (RISE_ONLY) begin : g_rise
            assign evt = cur & ~prev_q;
        end else begin : g_any
            assign evt = cur ^ prev_q;
        end
    endgenerate
endmodule

// File: rtl/pdw_monitor.sv
module pdw_monitor #(
    parameter int NCH         = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ENTRY_EDGE  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_in,
    input  logic           sclk_in,
    input  logic [NCH-1:0] chan_in,
    input  logic [NCH-1:0] chan_analog,
    input  logic [NCH-1:0] wake_en,
    input  logic           pd_cmd,
    input  logic           pd_mode,
    input  logic           ref_int,
    input  logic           ref_ext,
    output logic           dio_out,
    output logic           dio_oe,
    output logic           powered_down,
    output logic           wake_seen,
    output logic           ref_warn
);
    import pdw_pkg::*;

    localparam int CNT_W = $clog2(ENTRY_EDGE + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ENTRY_EDGE - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(ENTRY_EDGE);

    typedef struct packed {
        pdw_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             mode;
        logic             warn;
    } mon_regs_t;

    mon_regs_t r_q, r_d;

    logic [NCH-1:0] chan_s, chan_tog;
    logic           start_s, sclk_s, sclk_rise;
    logic           wake_hit;

    pdw_sync #(.W(NCH), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_sync_chan (
        .clk(clk), .rst_n(rst_n), .d_in(chan_in), .q_out(chan_s));

    pdw_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_start (
        .clk(clk), .rst_n(rst_n), .d_in(start_in), .q_out(start_s));

    pdw_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sclk (
        .clk(clk), .rst_n(rst_n), .d_in(sclk_in), .q_out(sclk_s));

    pdw_edge #(.W(NCH), .RISE_ONLY(1'b0), .RST_VAL('0)) i_edge_chan (
        .clk(clk), .rst_n(rst_n), .cur(chan_s), .evt(chan_tog));

    pdw_edge #(.W(1), .RISE_ONLY(1'b1), .RST_VAL(1'b0)) i_edge_sclk (
        .clk(clk), .rst_n(rst_n), .cur(sclk_s), .evt(sclk_rise));

    assign wake_hit = |(chan_tog & ~chan_analog & wake_en);

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (!start_s) begin
                    r_d.state = ST_CMD;
                    r_d.cnt   = '0;
                end
            end
            ST_CMD: begin
                if (start_s) begin
                    r_d.state = ST_IDLE;
                end else if (sclk_rise && r_q.cnt != CNT_SAT) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_LAST && pd_cmd) begin
                        r_d.state = ST_SLEEP;
                        r_d.mode  = pd_mode;
                        r_d.warn  = ref_int | ref_ext;
                    end
                end
            end
            ST_SLEEP: begin
                if (start_s) begin
                    r_d.state = ST_IDLE;
                    r_d.warn  = 1'b0;
                end else if (wake_hit) begin
                    r_d.state = ST_WOKE;
                end
            end
            ST_WOKE: begin
                if (start_s) begin
                    r_d.state = ST_IDLE;
                    r_d.warn  = 1'b0;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.cnt   <= '0;
            r_q.mode  <= 1'b0;
            r_q.warn  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign powered_down = (r_q.state == ST_SLEEP) || (r_q.state == ST_WOKE);
    assign wake_seen    = (r_q.state == ST_WOKE);
    assign dio_oe       = powered_down;
    assign dio_out      = powered_down & (r_q.mode ^ wake_seen);
    assign ref_warn     = r_q.warn;
endmodule

// File: rtl/pdw_monitor_chk.sv
module pdw_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic start_lvl,
    input logic pd_cmd,
    input logic dio_out,
    input logic powered_down,
    input logic wake_seen,
    input logic ref_warn
);
    // R2: sleep is entered only when the sleep command was present
    assert_entry_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(powered_down) |-> $past(pd_cmd));

    // R4 / R5: the wake event inverts the data line
    assert_wake_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_seen) |-> (dio_out != $past(dio_out)));

    // R6: a wake can only follow a sleep cycle
    assert_wake_in_sleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_seen) |-> $past(powered_down));

    // R8: line latched after the wake event
    assert_hold_after_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_seen && $past(wake_seen)) |-> $stable(dio_out));

    // R12: resting level steady while asleep and not woken
    assert_rest_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (powered_down && $past(powered_down) && !wake_seen) |-> $stable(dio_out));

    // R9: sleep ends only with the strobe high
    assert_exit_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(powered_down) |-> $past(start_lvl));

    // R11: warning confined to the sleep phase
    assert_warn_scope_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ref_warn |-> powered_down);
endmodule

bind pdw_monitor pdw_monitor_chk i_pdw_monitor_chk (
    .clk(clk),
    .rst_n(rst_n),
    .start_lvl(start_s),
    .pd_cmd(pd_cmd),
    .dio_out(dio_out),
    .powered_down(powered_down),
    .wake_seen(wake_seen),
    .ref_warn(ref_warn)
);

// File: tb/test_pdw_monitor.sv
module test_pdw_monitor;
    localparam int NCH = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_in = 1'b1;
    logic           sclk_in = 1'b0;
    logic [NCH-1:0] chan_in = '0;
    logic [NCH-1:0] chan_analog = 8'b1000_0011;
    logic [NCH-1:0] wake_en = 8'b0000_1101;
    logic           pd_cmd = 1'b0;
    logic           pd_mode = 1'b0;
    logic           ref_int = 1'b0;
    logic           ref_ext = 1'b0;
    logic           dio_out, dio_oe, powered_down, wake_seen, ref_warn;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pdw_monitor #(.NCH(NCH)) i_pdw_monitor (
        .clk(clk), .rst_n(rst_n), .start_in(start_in), .sclk_in(sclk_in),
        .chan_in(chan_in), .chan_analog(chan_analog), .wake_en(wake_en),
        .pd_cmd(pd_cmd), .pd_mode(pd_mode), .ref_int(ref_int), .ref_ext(ref_ext),
        .dio_out(dio_out), .dio_oe(dio_oe), .powered_down(powered_down),
        .wake_seen(wake_seen), .ref_warn(ref_warn));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk_pulse();
        sclk_in = 1'b1; idle(4);
        sclk_in = 1'b0; idle(4);
    endtask

    // strobe low, then seven host clock edges, then the eighth
    task automatic enter(input logic cmd, input logic mode, input logic ri, input logic re, input string tag);
        pd_cmd = cmd; pd_mode = mode; ref_int = ri; ref_ext = re;
        start_in = 1'b0; idle(6);
        for (int i = 0; i < 7; i++) sclk_pulse();
        chk({tag, " R2 not down after 7 edges"}, powered_down, 1'b0);
        sclk_pulse();
    endtask

    task automatic leave();
        start_in = 1'b1; idle(6);
        chk("R9 powered_down cleared", powered_down, 1'b0);
        chk("R9 dio_oe released", dio_oe, 1'b0);
        chk("R9 dio_out low", dio_out, 1'b0);
        chk("R9 wake_seen cleared", wake_seen, 1'b0);
        chk("R11 warn cleared at exit", ref_warn, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1 powered_down", powered_down, 1'b0);
        chk("R1 dio_oe", dio_oe, 1'b0);
        chk("R1 dio_out", dio_out, 1'b0);
        chk("R1 wake_seen", wake_seen, 1'b0);
        chk("R1 ref_warn", ref_warn, 1'b0);
    endtask

    task automatic t_no_cmd();
        enter(1'b0, 1'b0, 1'b0, 1'b0, "nocmd");
        sclk_pulse(); sclk_pulse();
        chk("R3 no sleep without command", powered_down, 1'b0);
        chk("R3 line not driven", dio_oe, 1'b0);
        start_in = 1'b1; idle(6);
    endtask

    task automatic t_mode0();
        chan_in = 8'b0000_0000; idle(6);
        enter(1'b1, 1'b0, 1'b0, 1'b0, "mode0");
        chk("R2 down after 8th edge", powered_down, 1'b1);
        chk("R4 line driven", dio_oe, 1'b1);
        chk("R4 resting 0", dio_out, 1'b0);
        chk("R11 no warn with refs 0", ref_warn, 1'b0);
        chan_in[2] = 1'b1; idle(6);
        chk("R6 rising change wakes", wake_seen, 1'b1);
        chk("R4 woken level 1", dio_out, 1'b1);
        chan_in[2] = 1'b0; idle(6);
        chan_in[3] = 1'b1; idle(6);
        chk("R8 line holds after wake", dio_out, 1'b1);
        chk("R8 wake flag holds", wake_seen, 1'b1);
        leave();
    endtask

    task automatic t_mode1();
        chan_in = 8'b0000_1000; idle(6);
        enter(1'b1, 1'b1, 1'b1, 1'b0, "mode1");
        chk("R5 resting 1", dio_out, 1'b1);
        chk("R11 warn with ref bit set", ref_warn, 1'b1);
        chan_in[0] = 1'b1; idle(6);
        chk("R7 analog channel ignored", dio_out, 1'b1);
        chan_in[5] = 1'b1; idle(6);
        chk("R7 disabled channel ignored", dio_out, 1'b1);
        chk("R7 no wake flag", wake_seen, 1'b0);
        pd_mode = 1'b0; idle(6);
        chk("R12 mode change ignored", dio_out, 1'b1);
        // host clock held low from here on: R10
        chan_in[3] = 1'b0; idle(6);
        chk("R10 R6 falling change wakes without sclk", wake_seen, 1'b1);
        chk("R5 woken level 0", dio_out, 1'b0);
        chan_in[3] = 1'b1; idle(6);
        chk("R8 later change ignored", dio_out, 1'b0);
        leave();
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(3);
        t_reset();
        t_no_cmd();
        t_mode0();
        t_mode1();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule